// File: doc/BRIEF.md
# Genome-Configured LUT Logic Fabric

This block is a small programmable logic fabric. Everything it does comes from one configuration bit string, called the genome. The fabric is a row of cells. Each cell holds a K-input look-up table and one edge-triggered storage flop. The genome fixes three things: the truth table of every LUT, the source of every LUT input and every flop input, and the source of every primary output. Sources are chosen by a flat address. The primary inputs come first, and the cells follow them.

The genome arrives on a one-bit serial port, least significant bit first. Each clock edge takes one bit while the load enable is high. The port never applies back-pressure: every bit shown with the enable high is consumed at that edge. The fabric keeps running on its old genome until the last bit of a complete load is captured. It then switches to the new genome at that same edge. While a load is in progress, all cell flops are held at zero, so a new genome always starts from a cleared state. The primary outputs are combinational functions of the primary inputs and the flop state.

Top module: `genome_fabric`

## Requirements
- R1: The genome is CFG_LEN = NOUT*(BPV+1) + (2^BPV - NIN)*(2^K + (K+1)*(BPV+1)) bits long. It is shifted in while cfg_en is high, one bit per clock edge, and the first bit shifted becomes genome bit 0.
- R2: The active genome is replaced only at the edge that captures bit CFG_LEN-1 of a load. If cfg_en drops before that, the active genome is left unchanged and the next load starts again from bit 0.
- R3: In every select field of BPV+1 bits, bits BPV-1:0 carry an address. Addresses 0 to NIN-1 are primary inputs pin[a], and address NIN+c is cell c. For a primary-input address, bit BPV has no effect.
- R4: For a cell address, bit BPV of the select field picks the cell's combinational LUT output when it is 0 and the cell's flop output when it is 1.
- R5: Output o is driven combinationally by the signal that the field at genome bits [o*(BPV+1) +: BPV+1] selects.
- R6: Cell j's gene starts at bit NOUT*(BPV+1) + j*(2^K + (K+1)*(BPV+1)). The gene holds, in order: 2^K truth-table bits, then K LUT input select fields (input 0 first), then one flop input select field.
- R7: A LUT's output is truth-table bit i, where i is the LUT input vector read with input 0 as bit 0.
- R8: A combinational select on a LUT input of cell j that names cell c with c >= j is served from cell c's flop output instead. Flop input selects and output selects may use the LUT output of any cell.
- R9: After reset, the genome and all flops are zero. At an edge where cfg_en is low, each flop loads its selected input. At an edge where cfg_en is high, every flop is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock for the loader and the cell flops |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Load enable: a bit is taken at every edge where this is high |
| cfg_bit | input | 1 | Serial genome bit, least significant bit first |
| pin | input | NIN | Primary inputs, at addresses 0 to NIN-1 |
| pout | output | NOUT | Primary outputs, one per output select field |

## Verification
Two directed genomes have outputs that are easy to predict by hand. The first is a self-feeding toggle cell. A design without the R8 loop break, or with the register bit inverted, would oscillate combinationally or would fail to alternate between 0 and 1. The second is a pair of AND-type tables. A truth table indexed with the bits reversed, or gene fields at the wrong offsets, would show up as wrong outputs on the four input patterns. An aborted partial load must leave the toggle running, and the outputs are compared during every load cycle. These checks catch a genome applied too early, a bit count that does not restart, and flops that are not cleared during a load. Many random genomes are then compared cycle by cycle against a reference model in the bench.

// File: rtl/gf_pkg.sv
package gf_pkg;

  // Where a select field finally takes its value from
  typedef enum logic [1:0] {
    SRC_PIN  = 2'd0,
    SRC_COMB = 2'd1,
    SRC_REG  = 2'd2
  } src_kind_e;

  // Resolve a select field; lut_in marks a LUT input of cell 'consumer',
  // where a combinational tap on the same or a later cell is turned into a
  // registered tap so no loop can form.
  function automatic src_kind_e classify(input int addr, input logic reg_bit,
                                         input int n_pin, input int consumer,
                                         input logic lut_in);
    if (addr < n_pin) return SRC_PIN;
    if (reg_bit) return SRC_REG;
    if (lut_in && (addr - n_pin) >= consumer) return SRC_REG;
    return SRC_COMB;
  endfunction

endpackage

// File: rtl/gf_cfg_loader.sv
module gf_cfg_loader #(
  parameter int LEN = 88
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_en,
  input  logic           cfg_bit,
  output logic [LEN-1:0] cfg_q,
  output logic           loading
);
  localparam int CW = $clog2(LEN + 1);

  logic [LEN-1:0] shreg;
  logic [CW-1:0]  cnt;
  logic           last;

  assign last    = cfg_en && (cnt == CW'(LEN - 1));
  assign loading = cfg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      cfg_q <= '0;
    end else begin
      if (cfg_en) begin
        shreg <= {cfg_bit, shreg[LEN-1:1]};
        cnt   <= last ? '0 : cnt + 1'b1;
      end else begin
        cnt <= '0;
      end
      if (last) cfg_q <= {cfg_bit, shreg[LEN-1:1]};
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt < CW'(LEN)); // R1
  AST_CFG_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !cfg_en |=> $stable(cfg_q)); // R2
  AST_COMMIT_FULL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(cfg_q) |-> $past(cfg_en && (cnt == CW'(LEN - 1)))); // R2

endmodule

// File: rtl/gf_eval.sv
module gf_eval
  import gf_pkg::*;
#(
  parameter int NIN   = 3,
  parameter int NOUT  = 2,
  parameter int BPV   = 3,
  parameter int K     = 2,
  parameter int NCELL = 5,
  parameter int LEN   = 88
) (
  input  logic [LEN-1:0]   cfg,
  input  logic [NIN-1:0]   pin,
  input  logic [NCELL-1:0] ffq,
  output logic [NCELL-1:0] d_o,
  output logic [NOUT-1:0]  pout
);
  localparam int SW    = BPV + 1;
  localparam int TTW   = 1 << K;
  localparam int GENE  = TTW + (K + 1) * SW;
  localparam int OBASE = NOUT * SW;
  localparam int NADDR = 1 << BPV;
  localparam int CIW   = (NCELL > 1) ? $clog2(NCELL) : 1;
  localparam int KIW   = (K > 1) ? $clog2(K) : 1;
  localparam int OIW   = (NOUT > 1) ? $clog2(NOUT) : 1;

  logic [TTW-1:0]        tt   [NCELL];
  logic [K-1:0][SW-1:0]  lsel [NCELL];
  logic [SW-1:0]         dsel [NCELL];
  logic [SW-1:0]         osel [NOUT];
  logic [NADDR-1:0]      rv;

  // Fixed field positions in the genome
  for (genvar o = 0; o < NOUT; o++) begin : g_ofld
    assign osel[o] = cfg[o*SW +: SW];
  end

  for (genvar j = 0; j < NCELL; j++) begin : g_gene
    localparam int GB = OBASE + j * GENE;
    assign tt[j]   = cfg[GB +: TTW];
    assign lsel[j] = cfg[GB + TTW +: K*SW];
    assign dsel[j] = cfg[GB + TTW + K*SW +: SW];
  end

  // Registered view of the address space: pins then flops
  assign rv = {ffq, pin};

  function automatic logic pick(input logic [SW-1:0] f, input int consumer,
                                input logic lut_in,
                                input logic [NADDR-1:0] cvv,
                                input logic [NADDR-1:0] rvv);
    src_kind_e s;
    s = classify(int'(f[BPV-1:0]), f[BPV], NIN, consumer, lut_in);
    if (s == SRC_REG) return rvv[f[BPV-1:0]];
    return cvv[f[BPV-1:0]];
  endfunction

  // Cells evaluated in address order; a cell only reads LUT outputs of
  // cells below it, which are already final.
  always_comb begin
    logic [NADDR-1:0] cv;
    logic [K-1:0]     idx;
    cv  = rv;
    idx = '0;
    for (int j = 0; j < NCELL; j++) begin
      for (int k = 0; k < K; k++) begin
        idx[KIW'(k)] = pick(lsel[CIW'(j)][KIW'(k)], j, 1'b1, cv, rv);
      end
      cv[BPV'(NIN + j)] = tt[CIW'(j)][idx];
    end
    for (int j = 0; j < NCELL; j++) begin
      d_o[CIW'(j)] = pick(dsel[CIW'(j)], NCELL, 1'b0, cv, rv);
    end
    for (int o = 0; o < NOUT; o++) begin
      pout[OIW'(o)] = pick(osel[OIW'(o)], NCELL, 1'b0, cv, rv);
    end
  end

endmodule

// File: rtl/gf_state.sv
module gf_state #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (hold) q <= '0;
    else           q <= d;
  end

  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) hold |=> (q == '0)); // R9

endmodule

// File: rtl/genome_fabric.sv
module genome_fabric #(
  parameter int NIN  = 3,
  parameter int NOUT = 2,
  parameter int BPV  = 3,
  parameter int K    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_bit,
  input  logic [NIN-1:0]  pin,
  output logic [NOUT-1:0] pout
);
  localparam int NCELL   = (1 << BPV) - NIN;
  localparam int SW      = BPV + 1;
  localparam int CFG_LEN = NOUT * SW + NCELL * ((1 << K) + (K + 1) * SW);

  logic [CFG_LEN-1:0] cfg_q;
  logic               loading;
  logic [NCELL-1:0]   ffq;
  logic [NCELL-1:0]   d_next;

  gf_cfg_loader #(.LEN(CFG_LEN)) u_loader (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_bit (cfg_bit),
    .cfg_q   (cfg_q),
    .loading (loading)
  );

  gf_eval #(
    .NIN(NIN), .NOUT(NOUT), .BPV(BPV), .K(K), .NCELL(NCELL), .LEN(CFG_LEN)
  ) u_eval (
    .cfg  (cfg_q),
    .pin  (pin),
    .ffq  (ffq),
    .d_o  (d_next),
    .pout (pout)
  );

  gf_state #(.N(NCELL)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (loading),
    .d     (d_next),
    .q     (ffq)
  );

endmodule

// File: tb/test_genome_fabric.sv
module test_genome_fabric;
  localparam int PERIOD = 10;
  localparam int NIN = 3, NOUT = 2, BPV = 3, K = 2;
  localparam int NCELL = (1 << BPV) - NIN;
  localparam int SW = BPV + 1;
  localparam int TTW = 1 << K;
  localparam int GENE = TTW + (K + 1) * SW;
  localparam int OB = NOUT * SW;
  localparam int LEN_EXP = NOUT * SW + NCELL * GENE;

  logic clk = 0, rst_n = 0, cfg_en = 0, cfg_bit = 0;
  logic [NIN-1:0] pin = '0;
  wire  [NOUT-1:0] pout;
  int total = 0, bad = 0;
  bit done = 0;
  logic [LEN_EXP-1:0] g_act = '0;
  logic [NCELL-1:0] ff_m = '0;

  always #(PERIOD/2) clk = ~clk;

  genome_fabric #(.NIN(NIN), .NOUT(NOUT), .BPV(BPV), .K(K)) i_genome_fabric (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit), .pin(pin), .pout(pout));

  function automatic logic [SW-1:0] fld(input logic [LEN_EXP-1:0] g, input int pos);
    return g[pos +: SW];
  endfunction

  function automatic logic src(input logic [SW-1:0] f, input int j, input bit lutin,
                               input logic [NIN-1:0] p, input logic [NCELL-1:0] fv,
                               input logic [NCELL-1:0] lv);
    int a;
    a = int'(f[BPV-1:0]);
    if (a < NIN) return p[a];
    if (f[BPV] || (lutin && (a - NIN) >= j)) return fv[a - NIN];
    return lv[a - NIN];
  endfunction

  task automatic model(input logic [LEN_EXP-1:0] g, input logic [NIN-1:0] p,
                       input logic [NCELL-1:0] fv, output logic [NOUT-1:0] o,
                       output logic [NCELL-1:0] dn);
    logic [NCELL-1:0] lv;
    lv = '0;
    for (int j = 0; j < NCELL; j++) begin
      int base, idx;
      base = OB + j * GENE;
      idx = 0;
      for (int k = 0; k < K; k++)
        if (src(fld(g, base + TTW + k * SW), j, 1, p, fv, lv)) idx |= (1 << k);
      lv[j] = g[base + idx];
    end
    for (int j = 0; j < NCELL; j++)
      dn[j] = src(fld(g, OB + j * GENE + TTW + K * SW), 0, 0, p, fv, lv);
    for (int oi = 0; oi < NOUT; oi++)
      o[oi] = src(fld(g, oi * SW), 0, 0, p, fv, lv);
  endtask

  task automatic check(input string tag, input logic [NOUT-1:0] act, input logic [NOUT-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: pout=%b expected=%b", tag, act, exp);
    end
  endtask

  // Called at a negedge with pin already driven; checks, then advances one edge
  task automatic cycle(input string tag, input bit have_exp, input logic [NOUT-1:0] exp);
    logic [NOUT-1:0] eo;
    logic [NCELL-1:0] dn;
    #1;
    model(g_act, pin, ff_m, eo, dn);
    check(tag, pout, eo);
    if (have_exp) check({tag, " directed"}, pout, exp);
    @(posedge clk);
    ff_m = dn;
    @(negedge clk);
  endtask

  task automatic load(input logic [LEN_EXP-1:0] g_new, input int nbits);
    logic [NOUT-1:0] eo;
    logic [NCELL-1:0] dn;
    for (int i = 0; i < nbits; i++) begin
      cfg_en = 1;
      cfg_bit = g_new[i];
      pin = NIN'($urandom);
      @(posedge clk);
      ff_m = '0;
      if (i == LEN_EXP - 1) g_act = g_new;
      @(negedge clk);
      model(g_act, pin, ff_m, eo, dn);
      check("R2/R9 during load", pout, eo);
    end
    cfg_en = 0;
    cfg_bit = 0;
  endtask

  function automatic logic [SW-1:0] mk(input bit rb, input int addr);
    return {rb, BPV'(addr)};
  endfunction

  logic [LEN_EXP-1:0] g_tog, g_and, g_rnd;

  initial begin
    void'($urandom(32'd7919));
    // toggle genome: out0 = flop of cell0, out1 = pin2 with reg bit set (ignored)
    g_tog = '0;
    g_tog[0 +: SW] = mk(1, NIN);
    g_tog[SW +: SW] = mk(1, 2);
    g_tog[OB +: TTW] = 4'b0101;                     // output = !in0
    g_tog[OB + TTW +: SW] = mk(0, NIN);             // in0: own comb -> served from flop (R8)
    g_tog[OB + TTW + SW +: SW] = mk(0, 1);
    g_tog[OB + TTW + K * SW +: SW] = mk(0, NIN);    // D = own LUT output
    // AND genome: cell0 = p0&p1, cell1 = p0&!p1
    g_and = '0;
    g_and[0 +: SW] = mk(0, NIN);
    g_and[SW +: SW] = mk(0, NIN + 1);
    g_and[OB +: TTW] = 4'b1000;
    g_and[OB + TTW +: SW] = mk(0, 0);
    g_and[OB + TTW + SW +: SW] = mk(0, 1);
    g_and[OB + GENE +: TTW] = 4'b0010;
    g_and[OB + GENE + TTW +: SW] = mk(0, 0);
    g_and[OB + GENE + TTW + SW +: SW] = mk(0, 1);

    // R9 reset state: zero genome routes pin0 to all outputs
    pin = 3'b001;
    repeat (2) @(negedge clk);
    check("R9 reset pin0", pout, {NOUT{1'b1}});
    pin = 3'b110;
    #1;
    check("R9 reset pin0", pout, {NOUT{1'b0}});
    rst_n = 1;
    @(negedge clk);

    // R1 length
    total++;
    if (i_genome_fabric.CFG_LEN != LEN_EXP) begin
      bad++;
      $display("FAIL R1 length: got=%0d expected=%0d", i_genome_fabric.CFG_LEN, LEN_EXP);
    end

    // R8 / R4 / R3 toggle cell
    load(g_tog, LEN_EXP);
    for (int t = 0; t < 6; t++) begin
      pin = NIN'($urandom);
      cycle("R8 R4 R3 toggle", 1, {pin[2], 1'(t % 2)});
    end

    // R2 aborted partial load keeps toggle genome, flops cleared
    g_rnd = '1;
    load(g_rnd, LEN_EXP / 2);
    for (int t = 0; t < 4; t++) begin
      pin = NIN'($urandom);
      cycle("R2 partial load", 1, {pin[2], 1'(t % 2)});
    end

    // R7 / R6 / R5 truth table indexing
    load(g_and, LEN_EXP);
    for (int v = 0; v < 4; v++) begin
      pin = NIN'(v);
      cycle("R7 R6 R5 table index", 1, {1'(v == 1), 1'(v == 3)});
    end

    // random genomes against the model
    for (int n = 0; n < 30; n++) begin
      for (int i = 0; i < LEN_EXP; i++) g_rnd[i] = 1'($urandom);
      load(g_rnd, LEN_EXP);
      for (int t = 0; t < 12; t++) begin
        pin = NIN'($urandom);
        cycle("R3-model random", 0, '0);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule